// File: doc/BRIEF.md
# Glitch-Safe PLL Reconfiguration Sequencer

This block moves a chip's system clock from whatever it is running on to a new PLL setting without letting a runt clock pulse reach the core. A single start strobe, qualified by a 32-bit target word, makes it issue three writes to the clock-configuration register, each marked by a one-cycle write strobe.

The first write parks the clock on the fast internal RC oscillator. It also forces the post-divider code to its all-ones value. Because of that, the sequencer never needs to know the current clock mode:

- Entering the all-ones code cannot glitch.
- Keeping the all-ones code unchanged cannot glitch either.

The second write loads the full new setting while the RC oscillator stays selected. After a programmable settle time, the third write selects the PLL.

The analog PLL, the oscillators and the clock multiplexer lie outside the block. It only produces the register writes and their timing. Busy covers the whole sequence, and done pulses once when the sequence ends.

Top module: `pll_hop_top`

Word layout used throughout: bits 1:0 source select (00 = RC oscillator, 11 = PLL), bits 3:2 oscillator mode, bits 7:4 post-divider code (1111 = divide by one), bits 24:8 enable, input divider and multiplier.

## Requirements
- R1: While reset is held and after it is released, `cfg_o` is all zeros (RC selected) and `cfg_wr_o`, `busy_o` and `done_o` are low.
- R2: One cycle after a start is accepted, `cfg_wr_o` is high and `cfg_o` has bits 7:4 = 1111, bits 3:2 copied from the target, and every other bit zero.
- R3: One cycle after the first write, a second write carries the target word with bits 1:0 forced to 00.
- R4: Exactly SETTLE_CYCLES cycles after the second write, a third write carries the target word with bits 1:0 forced to 11.
- R5: `cfg_wr_o` is high for exactly three cycles per request: the three write cycles and no others.
- R6: `busy_o` is high from the first write through the cycle of the third write. One cycle after the third write, `done_o` pulses for one cycle and `busy_o` is low in that same cycle.
- R7: A start that arrives while busy is ignored: no extra writes occur, and the written words depend only on the target captured when the start was accepted.
- R8: `cfg_o` holds its value in every cycle in which `cfg_wr_o` is low.
- R9: Any write made while the previous word selected the PLL (bits 1:0 = 11) selects the RC oscillator (00) and has post-divider 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| target_cfg_i | input | 32 | Desired final configuration word |
| cfg_o | output | 32 | Configuration register value |
| cfg_wr_o | output | 1 | One-cycle write strobe for `cfg_o` |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Take the clock edge that accepts a start as cycle 0. The park write is then visible just after that edge. The staging write follows one cycle later, and the engage write comes at cycle 1+SETTLE_CYCLES. Done, together with busy falling, comes at cycle 2+SETTLE_CYCLES.

The bench samples on the falling edge and indexes each sample by the cycle count since the accepting edge. Every write word, strobe, busy and done value is compared against that schedule in every cycle of the run, including the cycles where nothing may happen. Extra starts are injected at random points inside the busy window, and the target input is scrambled every cycle. Both must leave the schedule and the words untouched.

// File: rtl/pll_hop_pkg.sv
package pll_hop_pkg;
  localparam int CFG_W     = 32;
  localparam int SEL_LSB   = 0;
  localparam int OSC_LSB   = 2;
  localparam int PDIV_LSB  = 4;
  localparam logic [1:0] SEL_RC    = 2'b00;
  localparam logic [1:0] SEL_PLL   = 2'b11;
  localparam logic [3:0] PDIV_SAFE = 4'hF;

  typedef enum logic [1:0] {PH_PARK, PH_STAGE, PH_ENGAGE} phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_STAGE, ST_SETTLE, ST_ENGAGE} state_e;

  // Park: RC selected, safe post-divider, requested oscillator mode, all else zero.
  function automatic logic [CFG_W-1:0] park_word(input logic [CFG_W-1:0] t);
    logic [CFG_W-1:0] w;
    w = '0;
    w[PDIV_LSB +: 4] = PDIV_SAFE;
    w[OSC_LSB +: 2]  = t[OSC_LSB +: 2];
    w[SEL_LSB +: 2]  = SEL_RC;
    return w;
  endfunction

  // Stage: full target, but still running from RC.
  function automatic logic [CFG_W-1:0] stage_word(input logic [CFG_W-1:0] t);
    logic [CFG_W-1:0] w;
    w = t;
    w[SEL_LSB +: 2] = SEL_RC;
    return w;
  endfunction

  // Engage: full target with the PLL selected.
  function automatic logic [CFG_W-1:0] engage_word(input logic [CFG_W-1:0] t);
    logic [CFG_W-1:0] w;
    w = t;
    w[SEL_LSB +: 2] = SEL_PLL;
    return w;
  endfunction
endpackage

// File: rtl/pll_hop_word_mux.sv
module pll_hop_word_mux
  import pll_hop_pkg::*;
(
  input  phase_e           phase_i,
  input  logic [CFG_W-1:0] target_i,
  output logic [CFG_W-1:0] word_o
);
  always_comb begin
    case (phase_i)
      PH_PARK:   word_o = park_word(target_i);
      PH_STAGE:  word_o = stage_word(target_i);
      default:   word_o = engage_word(target_i);
    endcase
  end
endmodule

// File: rtl/pll_hop_settle_timer.sv
module pll_hop_settle_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  // R4: the settle count never runs past its final value
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R4: the count starts from zero when the settle window opens
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/pll_hop_ctrl.sv
module pll_hop_ctrl
  import pll_hop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CFG_W-1:0] target_i,
  input  logic [CFG_W-1:0] word_i,
  input  logic             settle_done_i,
  output phase_e           phase_o,
  output logic [CFG_W-1:0] word_target_o,
  output logic             timer_clear_o,
  output logic             timer_run_o,
  output logic             accept_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             wr_o,
  output logic             busy_o,
  output logic             done_o
);
  state_e           state_q;
  logic [CFG_W-1:0] target_q;
  logic [CFG_W-1:0] cfg_q;
  logic             wr_q, busy_q, done_q;
  logic [1:0]       wr_seen_q;

  assign accept_o      = (state_q == ST_IDLE) && start_i;
  assign timer_clear_o = (state_q == ST_STAGE);
  assign timer_run_o   = (state_q == ST_SETTLE);
  assign word_target_o = (state_q == ST_IDLE) ? target_i : target_q;

  always_comb begin
    case (state_q)
      ST_IDLE:  phase_o = PH_PARK;
      ST_STAGE: phase_o = PH_STAGE;
      default:  phase_o = PH_ENGAGE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      target_q <= '0;
      cfg_q    <= '0;
      wr_q     <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          target_q <= target_i;
          cfg_q    <= word_i;
          wr_q     <= 1'b1;
          busy_q   <= 1'b1;
          state_q  <= ST_STAGE;
        end
        ST_STAGE: begin
          cfg_q   <= word_i;
          wr_q    <= 1'b1;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_done_i) begin
          cfg_q   <= word_i;
          wr_q    <= 1'b1;
          state_q <= ST_ENGAGE;
        end
        default: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // write tally per request, kept for the assertions below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_seen_q <= '0;
    else if (accept_o) wr_seen_q <= 2'd1;
    else if (wr_q && wr_seen_q != 2'd3 && state_q != ST_IDLE) wr_seen_q <= wr_seen_q + 2'd1;
  end

  assign cfg_o  = cfg_q;
  assign wr_o   = wr_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R5: three writes have been seen when a request completes
  p_three_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> wr_seen_q == 2'd3);
  // R6: done follows the last write and coincides with busy low
  p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && $past(busy_q) && $past(wr_q));
  // R7: a start is never taken while busy
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> !busy_q);
  // R8: the register value only moves with a write
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_q |-> $stable(cfg_q));
  // R9: leaving the PLL always uses RC select and the safe post-divider
  p_leave_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && $past(cfg_q[SEL_LSB +: 2]) == SEL_PLL) |->
      (cfg_q[SEL_LSB +: 2] == SEL_RC && cfg_q[PDIV_LSB +: 4] == PDIV_SAFE));
endmodule

// File: rtl/pll_hop_top.sv
module pll_hop_top #(
  parameter int SETTLE_CYCLES = 250000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [31:0] target_cfg_i,
  output logic [31:0] cfg_o,
  output logic        cfg_wr_o,
  output logic        busy_o,
  output logic        done_o
);
  import pll_hop_pkg::*;

  phase_e           phase;
  logic [CFG_W-1:0] word_target;
  logic [CFG_W-1:0] word;
  logic             timer_clear, timer_run, settle_done, accept;

  pll_hop_word_mux u_words (
    .phase_i  (phase),
    .target_i (word_target),
    .word_o   (word)
  );

  pll_hop_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (timer_clear),
    .run_i     (timer_run),
    .expired_o (settle_done)
  );

  pll_hop_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .target_i      (target_cfg_i),
    .word_i        (word),
    .settle_done_i (settle_done),
    .phase_o       (phase),
    .word_target_o (word_target),
    .timer_clear_o (timer_clear),
    .timer_run_o   (timer_run),
    .accept_o      (accept),
    .cfg_o         (cfg_o),
    .wr_o          (cfg_wr_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  // R2: an accepted start produces the park write on the next cycle
  p_park_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cfg_wr_o && cfg_o[7:4] == 4'hF && cfg_o[1:0] == 2'b00);
  // R4: the engage write selects the PLL
  p_engage_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |=> cfg_wr_o && cfg_o[1:0] == 2'b11);
endmodule

// File: tb/test_pll_hop_top.sv
`timescale 1ns/1ps
module test_pll_hop_top;
  localparam int S = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] tgt = '0;
  logic [31:0] cfg;
  logic        wr, busy, done;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pll_hop_top #(.SETTLE_CYCLES(S)) i_pll_hop_top (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_cfg_i(tgt),
    .cfg_o(cfg), .cfg_wr_o(wr), .busy_o(busy), .done_o(done)
  );

  function automatic logic [31:0] exp_park(input logic [31:0] t);
    return (t & 32'h0000_000C) | 32'h0000_00F0;
  endfunction
  function automatic logic [31:0] exp_stage(input logic [31:0] t);
    return t & 32'hFFFF_FFFC;
  endfunction
  function automatic logic [31:0] exp_engage(input logic [31:0] t);
    return t | 32'h0000_0003;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] t, input int inj);
    int nwr;
    logic [31:0] prev;
    nwr = 0;
    prev = cfg;
    @(negedge clk); start = 1'b1; tgt = t;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < S + 5; c++) begin
      chk("R5 strobe", {31'b0, wr}, {31'b0, (c == 0 || c == 1 || c == S + 1)});
      if (wr) begin
        nwr++;
        if (c == 0) begin
          chk("R2 park word", cfg, exp_park(t));
          if (prev[1:0] == 2'b11)
            chk("R9 leave pll", {24'b0, cfg[7:0] & 8'hF3}, 32'h0000_00F0);
        end else if (c == 1) chk("R3 stage word", cfg, exp_stage(t));
        else chk("R4 engage word", cfg, exp_engage(t));
      end else if (c > 1) begin
        chk("R8 hold", cfg, (c <= S) ? exp_stage(t) : exp_engage(t));
      end
      chk("R6 done", {31'b0, done}, {31'b0, (c == S + 2)});
      chk("R6 busy", {31'b0, busy}, {31'b0, (c <= S + 1)});
      tgt = $urandom;            // R7: target scrambled after capture
      start = (c == inj);        // R7: start inside busy window
      @(negedge clk);
    end
    start = 1'b0;
    chk("R7 write count", nwr, 3);
    chk("R7 final word", cfg, exp_engage(t));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1: reset state while held and after release
    chk("R1 cfg in reset", cfg, 32'h0);
    chk("R1 flags in reset", {29'b0, wr, busy, done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cfg after reset", cfg, 32'h0);
    chk("R1 flags after reset", {29'b0, wr, busy, done}, 32'h0);

    run_req(32'hFFFF_FFFF, 1);       // all ones, restart right away
    run_req(32'h0000_0000, S + 1);   // zero, restart on engage cycle
    run_req(32'h0100_64F7, S);       // divide-by-one PLL target
    run_req(32'h0100_64F7, 5);       // again from that PLL state
    for (int i = 0; i < 6; i++)
      run_req($urandom, 1 + ($urandom % (S + 1)));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule